// File: doc/BRIEF.md
# 32-Pin GPIO Port with Masked Halfword Writes

This block drives and samples a bank of 32 general-purpose pins behind a small word-addressed register interface. It keeps two writable logical registers, the output level of each pin and its drive enable. Each is 32 bits wide but is exposed as two bus words: one word covers pins 0 to 15 and the word four bytes above it covers pins 16 to 31. In every such bus word the upper sixteen bits act as per-bit write enables for the lower sixteen data bits. Software can therefore set or clear any subset of pins in one store, with no read-modify-write sequence and no lock between competing writers.

Two read-only words sit beside the writable registers. One returns the level of all 32 pins after a two-flop synchronizer. The other returns a fixed identification constant. Any other offset reads as zero. Writes to an offset that is not writable do nothing.

The bus side has plain strobes and never stalls. A write takes effect at the clock edge on which `bus_we` is sampled high. A read is accepted on every cycle that `bus_re` is high, and its data appears on `bus_rdata` one cycle later, marked by `bus_rvalid`. There is no back-pressure, so the requester may issue a read or a write on every cycle.

Top module: `gpio_hw_port`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first write, the output-level register and the drive-enable register are all zero. In this state `pin_out` and `pin_oe` are zero and every pin is an input.
- R2: A write to offset 0x00 updates output-level bit n (n in 0..15) from `bus_wdata[n]` only when `bus_wdata[n+16]` is 1. Every other bit keeps its value. Data 0 with enable 1 clears a pin, and data 1 with enable 1 sets it.
- R3: A write to offset 0x04 applies the same masked rule to output-level bits 16..31, taking data from `bus_wdata[15:0]` and enables from `bus_wdata[31:16]`. It leaves bits 0..15 untouched, and a write to 0x00 leaves bits 16..31 untouched.
- R4: The drive-enable register follows the same masked rule at offsets 0x08 (pins 0..15) and 0x0C (pins 16..31). A bit value of 1 means the pin drives and 0 means it is an input.
- R5: `pin_out` equals the output-level register and `pin_oe` equals the drive-enable register. A write becomes visible on the pins at the clock edge that samples it.
- R6: A read of 0x00, 0x04, 0x08 or 0x0C returns the 16 stored bits of that half in `bus_rdata[15:0]`, with zeros in bits [31:16]. A read issued in the same cycle as a write returns the value from before that write.
- R7: A read of offset 0x70 returns all 32 pins as one word, as they were sampled two clock edges before the read is sampled. This is the value after a two-flop synchronizer, and the synchronizer resets to zero.
- R8: A read of offset 0x78 returns the constant 0x01000C2B.
- R9: A read of any other offset, including an unaligned one, returns zero. A write to 0x70, 0x78 or any unmapped offset changes no register.
- R10: `bus_rvalid` is high in exactly the cycles that follow a cycle with `bus_re` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data: enables in [31:16], data in [15:0] for halfword registers |
| bus_rdata | output | 32 | Read data, valid when bus_rvalid is high |
| bus_rvalid | output | 1 | High one cycle after a read strobe |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output level of each pin |
| pin_oe | output | 32 | Drive enable of each pin, 1 = output |

## Verification
The bound checker watches several rules on every cycle. It confirms that a write to one half leaves the other half and every unenabled bit stable. It confirms that writes to read-only or unmapped offsets leave both registers alone, that the pins hold when no write occurs, that the read-valid flag tracks the read strobe, and that the identification word is returned. Other behaviour needs sequences that only the bench's scenarios set up. This includes the actual values that enabled bits take, the two-edge latency of the pin synchronizer, zero reads of unaligned and unmapped offsets, and read-before-write ordering when a read and a write land in the same cycle. These scenarios are compared against a behavioural model on every clock.

// File: rtl/gpio_hw_pkg.sv
package gpio_hw_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_LEVEL = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DRIVE = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_PINS  = 8'h70;
  localparam logic [ADDR_W-1:0] OFF_IDENT = 8'h78;

  localparam logic [BUS_W-1:0] IDENT_WORD = 32'h0100_0C2B;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LEVEL,
    SEL_DRIVE,
    SEL_PINS,
    SEL_IDENT
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e sel;
    logic     upper;
  } decode_t;
endpackage

// File: rtl/gpio_hw_decode.sv
module gpio_hw_decode
  import gpio_hw_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output decode_t           dec
);
  localparam int unsigned PAIR_LSB = 3;

  always_comb begin
    dec.sel   = SEL_NONE;
    dec.upper = addr[2];
    if (addr[1:0] == 2'b00) begin
      if (addr[ADDR_W-1:PAIR_LSB] == OFF_LEVEL[ADDR_W-1:PAIR_LSB])
        dec.sel = SEL_LEVEL;
      else if (addr[ADDR_W-1:PAIR_LSB] == OFF_DRIVE[ADDR_W-1:PAIR_LSB])
        dec.sel = SEL_DRIVE;
      else if (addr == OFF_PINS)
        dec.sel = SEL_PINS;
      else if (addr == OFF_IDENT)
        dec.sel = SEL_IDENT;
    end
  end
endmodule

// File: rtl/gpio_hw_halfreg.sv
module gpio_hw_halfreg
  import gpio_hw_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             upper,
  input  logic [BUS_W-1:0] wdata,
  output logic [NPINS-1:0] q
);
  localparam int unsigned NHALF = NPINS / HALF_W;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic [HALF_W-1:0] bits_q;
    logic [HALF_W-1:0] en;
    logic              hit;

    assign hit = wr && (upper == h[0]);
    assign en  = wdata[BUS_W-1:HALF_W];

    always_ff @(posedge clk) begin
      if (!rst_n)
        bits_q <= '0;
      else if (hit)
        bits_q <= (bits_q & ~en) | (wdata[HALF_W-1:0] & en);
    end

    assign q[h*HALF_W +: HALF_W] = bits_q;
  end
endmodule

// File: rtl/gpio_hw_sync.sv
module gpio_hw_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_hw_port.sv
module gpio_hw_port
  import gpio_hw_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);
  localparam int unsigned PAD_W = BUS_W - HALF_W;

  decode_t          dec;
  logic [NPINS-1:0] level_q;
  logic [NPINS-1:0] drive_q;
  logic [NPINS-1:0] pins_sync;
  logic [BUS_W-1:0] rd_next;
  logic [BUS_W-1:0] rdata_q;
  logic             rvalid_q;

  gpio_hw_decode u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  gpio_hw_halfreg #(.NPINS(NPINS)) u_level (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_we && dec.sel == SEL_LEVEL),
    .upper (dec.upper),
    .wdata (bus_wdata),
    .q     (level_q)
  );

  gpio_hw_halfreg #(.NPINS(NPINS)) u_drive (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_we && dec.sel == SEL_DRIVE),
    .upper (dec.upper),
    .wdata (bus_wdata),
    .q     (drive_q)
  );

  gpio_hw_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pins_sync)
  );

  function automatic logic [BUS_W-1:0] pick_half(input logic [NPINS-1:0] v,
                                                 input logic upper);
    return upper ? {{PAD_W{1'b0}}, v[NPINS-1:HALF_W]}
                 : {{PAD_W{1'b0}}, v[HALF_W-1:0]};
  endfunction

  always_comb begin
    unique case (dec.sel)
      SEL_LEVEL: rd_next = pick_half(level_q, dec.upper);
      SEL_DRIVE: rd_next = pick_half(drive_q, dec.upper);
      SEL_PINS:  rd_next = pins_sync;
      SEL_IDENT: rd_next = IDENT_WORD;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_re;
      if (bus_re) rdata_q <= rd_next;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign pin_out    = level_q;
  assign pin_oe     = drive_q;
endmodule

// File: rtl/gpio_hw_port_chk.sv
module gpio_hw_port_chk
  import gpio_hw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic              bus_re,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              bus_rvalid,
  input logic [31:0]       pin_out,
  input logic [31:0]       pin_oe
);
  logic wr_lo_level, wr_hi_level, wr_ro;

  assign wr_lo_level = bus_we && bus_addr == 8'h00;
  assign wr_hi_level = bus_we && bus_addr == 8'h04;
  assign wr_ro = bus_we && !(bus_addr == 8'h00 || bus_addr == 8'h04 ||
                             bus_addr == 8'h08 || bus_addr == 8'h0C);

  // R2: bits whose enable is zero keep their level
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_level |=> (((pin_out[15:0] ^ $past(pin_out[15:0])) &
                      ~$past(bus_wdata[31:16])) == 16'h0));

  // R3: a low-half write leaves the upper half alone
  p_half_iso_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_level |=> $stable(pin_out[31:16]));

  // R3: an upper-half write leaves the lower half alone
  p_half_iso_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi_level |=> $stable(pin_out[15:0]));

  // R5: without a write, the pins hold
  p_pins_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(pin_out) && $stable(pin_oe)));

  // R8: identification word
  p_ident_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == OFF_IDENT) |=> (bus_rdata == IDENT_WORD));

  // R9: writes to read-only or unmapped words change nothing
  p_ro_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ro |=> ($stable(pin_out) && $stable(pin_oe)));

  // R10: read-valid follows the read strobe
  p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> bus_rvalid);

  p_no_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> !bus_rvalid);
endmodule

bind gpio_hw_port gpio_hw_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_we     (bus_we),
  .bus_re     (bus_re),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe)
);

// File: tb/gpio_hw_port_test.sv
module gpio_hw_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] pin_in = 32'h0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  always #5 clk = ~clk;

  gpio_hw_port uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe)
  );

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 0;
  string tag = "R1";

  logic [31:0] m_level = 32'h0;
  logic [31:0] m_drive = 32'h0;
  logic [31:0] m_rdata = 32'h0;
  logic        m_rvalid = 1'b0;
  logic [31:0] hist[$] = '{32'h0, 32'h0};

  function automatic logic [15:0] merge(input logic [15:0] old,
                                        input logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  // behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    logic [31:0] rd;
    if (!rst_n) begin
      m_level = 0; m_drive = 0; m_rdata = 0; m_rvalid = 0;
      hist = '{32'h0, 32'h0};
    end else begin
      rd = 32'h0;
      case (bus_addr)
        8'h00: rd = {16'h0, m_level[15:0]};
        8'h04: rd = {16'h0, m_level[31:16]};
        8'h08: rd = {16'h0, m_drive[15:0]};
        8'h0C: rd = {16'h0, m_drive[31:16]};
        8'h70: rd = hist[0];
        8'h78: rd = 32'h0100_0C2B;
        default: rd = 32'h0;
      endcase
      m_rvalid = bus_re;
      if (bus_re) m_rdata = rd;
      if (bus_we) begin
        case (bus_addr)
          8'h00: m_level[15:0]  = merge(m_level[15:0], bus_wdata);
          8'h04: m_level[31:16] = merge(m_level[31:16], bus_wdata);
          8'h08: m_drive[15:0]  = merge(m_drive[15:0], bus_wdata);
          8'h0C: m_drive[31:16] = merge(m_drive[31:16], bus_wdata);
          default: ;
        endcase
      end
      hist.push_back(pin_in);
      void'(hist.pop_front());
    end
  end

  // comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (pin_out !== m_level) begin
        miscompares++;
        $display("FAIL %s pin_out actual %h expected %h", tag, pin_out, m_level);
      end
      if (pin_oe !== m_drive) begin
        miscompares++;
        $display("FAIL %s pin_oe actual %h expected %h", tag, pin_oe, m_drive);
      end
      if (bus_rvalid !== m_rvalid) begin
        miscompares++;
        $display("FAIL %s (R10) rvalid actual %b expected %b", tag, bus_rvalid, m_rvalid);
      end
      if (m_rvalid && bus_rdata !== m_rdata) begin
        miscompares++;
        $display("FAIL %s rdata actual %h expected %h", tag, bus_rdata, m_rdata);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic rd_all();
    rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h0C);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual still running, expected finished");
    finish_run();
  end

  initial begin
    // R1: reset state, held and after release
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_all();

    // R2: masked writes to the low half of the level register
    tag = "R2";
    wr(8'h00, 32'hFFFF_A5A5);
    wr(8'h00, 32'h00F0_0000);
    wr(8'h00, 32'h0001_0001);
    wr(8'h00, 32'h0000_FFFF);
    rd(8'h00);

    // R3: upper half independent of lower half
    tag = "R3";
    wr(8'h04, 32'hFFFF_1234);
    wr(8'h04, 32'h8000_0000);
    wr(8'h00, 32'h0002_0000);
    rd(8'h04); rd(8'h00);

    // R4: drive-enable register, both halves
    tag = "R4";
    wr(8'h08, 32'h00FF_00AA);
    wr(8'h0C, 32'hF000_5000);
    wr(8'h08, 32'h0003_0001);
    rd(8'h08); rd(8'h0C);

    // R5: pins follow the registers; no-write cycles hold
    tag = "R5";
    wr(8'h0C, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);

    // R6: read and write in the same cycle return the old value
    tag = "R6";
    @(negedge clk);
    bus_re = 1'b1; bus_we = 1'b1; bus_addr = 8'h04; bus_wdata = 32'hFFFF_0F0F;
    @(negedge clk);
    bus_re = 1'b0; bus_we = 1'b0;
    rd(8'h04);

    // R7: synchronized pin levels, with back-to-back reads around a change
    tag = "R7";
    pin_in = 32'hDEAD_BEEF;
    @(negedge clk);
    bus_re = 1'b1; bus_addr = 8'h70;
    repeat (4) @(negedge clk);
    pin_in = 32'h1234_5678;
    repeat (4) @(negedge clk);
    bus_re = 1'b0;
    pin_in = 32'h0000_0001;
    repeat (3) @(negedge clk);
    rd(8'h70);

    // R8: identification word
    tag = "R8";
    rd(8'h78);

    // R9: unmapped and unaligned reads, writes to read-only words
    tag = "R9";
    rd(8'h10); rd(8'h74); rd(8'h02); rd(8'h0E); rd(8'hFC);
    wr(8'h70, 32'hFFFF_FFFF);
    wr(8'h78, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    rd(8'h78); rd_all();

    // R10: idle cycles keep read-valid low
    tag = "R10";
    repeat (3) @(negedge clk);

    // R1: reset again clears everything
    tag = "R1";
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd_all();
    rd(8'h70);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule